// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block keeps an 8-bit count driven by one external input pin, and has two modes. In event mode the count advances once for each chosen transition of the pin. In gated mode the count advances once per internal time-base tick, but only while the pin sits at a chosen active level. The time base is made inside the block: it gives one tick every 256 system clocks. The count therefore measures how long the pin stayed active, in units of 256 clocks.

Software preloads the count through a simple write port. An overflow flag records a wrap from 0xFF to 0x00, and the count carries on. An input flag records each counted transition in event mode. In gated mode it marks the end of a gated interval. Both flags are cleared by writing ones to a clear port, and each drives an interrupt request through its own enable.

Top module: `pacc_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the count is 0x00, both flags are 0 and both interrupt requests are 0.
- R2: The pin passes through a two-stage synchronizer, so a selected transition applied before clock edge k changes the count at clock edge k+2.
- R3: With mode_gated_i=0, the count advances by one for each rising pin transition when pol_i=0, or for each falling transition when pol_i=1. Transitions of the other direction have no effect.
- R4: With mode_gated_i=1, the count advances by one on each time-base tick while the synchronized pin equals the active level (high when pol_i=0, low when pol_i=1). Ticks are exactly 256 clocks apart, and the first tick is at the 256th clock edge after reset is released.
- R5: While en_i=0 the count never advances and neither flag is set. Preload writes and flag clears still act.
- R6: An advance from 0xFF gives 0x00 and sets the overflow flag (flag bit 0). The count keeps advancing after that.
- R7: The input flag (flag bit 1) is set by each counted transition in event mode. In gated mode it is set by the trailing edge of the active level: falling when pol_i=0, rising when pol_i=1.
- R8: When cnt_wr_i=1, the count takes cnt_wdata_i on the next edge. This happens even if an advance falls in the same cycle, and that write causes no overflow.
- R9: When flag_clr_wr_i=1, each flag whose bit in flag_clr_i is 1 is cleared. If a flag is set in the same cycle, the set wins. Clear bits that are 0 leave their flag unchanged.
- R10: irq_ovf_o is the overflow flag ANDed with ie_ovf_i, and irq_in_o is the input flag ANDed with ie_in_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pin_i | input | 1 | Asynchronous accumulator input pin |
| mode_gated_i | input | 1 | 0 = event mode, 1 = gated mode |
| pol_i | input | 1 | Edge/level select (0 rising/high, 1 falling/low) |
| en_i | input | 1 | Accumulator enable |
| cnt_wr_i | input | 1 | Count preload strobe |
| cnt_wdata_i | input | 8 | Preload value |
| flag_clr_wr_i | input | 1 | Flag clear strobe |
| flag_clr_i | input | 2 | Write-1-to-clear mask: bit0 overflow, bit1 input |
| ie_ovf_i | input | 1 | Overflow interrupt enable |
| ie_in_i | input | 1 | Input flag interrupt enable |
| count_o | output | 8 | Current count |
| ovf_flag_o | output | 1 | Overflow flag |
| in_flag_o | output | 1 | Input flag |
| irq_ovf_o | output | 1 | Overflow interrupt request |
| irq_in_o | output | 1 | Input interrupt request |

## Verification
Faults in the synchronizer or edge detector show up on count_o two clock edges after a pin transition. The count may land one edge early or late, or move on the wrong direction of transition. A misphased time-base divider goes unseen until the first tick at clock 256, and after that every gated advance is off by the same amount. A broken flag path shows at the wrap or at the trailing edge of a gated interval, in the same edge that should set the flag. A reference model is compared with the outputs on every cycle, so any such drift is reported in the cycle where it first appears.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  localparam int CW = 8;
  typedef logic [CW-1:0] cnt_t;

  // Selected transition for the given polarity (0 rising, 1 falling).
  function automatic logic sel_edge(input logic cur, input logic prev, input logic pol);
    return pol ? (prev & ~cur) : (cur & ~prev);
  endfunction

  // Incremented count and its carry out of the top bit.
  function automatic logic [CW:0] bump(input cnt_t c);
    return {1'b0, c} + {{CW{1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o,
  output logic prev_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= pin_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sr_q[STAGES-1];
  end

  assign lvl_o  = sr_q[STAGES-1];
  assign prev_o = prev_q;

  // Cycles since reset, saturating, so the delay check never looks before reset.
  logic [1:0] age_q;
  always_ff @(posedge clk_i) begin
    if (!rst_ni)           age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R2: synchronized level follows the pin two edges later
  a_r2_sync_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (STAGES == 2 && age_q >= 2'd2) |-> (lvl_o == $past(pin_i, 2)));
endmodule

// File: rtl/pacc_tick.sv
module pacc_tick #(
  parameter int DIV = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)             div_q <= '0;
    else if (div_q == LAST)  div_q <= '0;
    else                     div_q <= div_q + 1'b1;
  end

  assign tick_o = (div_q == LAST);

  // Independent spacing counter for the tick period check.
  logic [DW:0] gap_q;
  always_ff @(posedge clk_i) begin
    if (!rst_ni)     gap_q <= '0;
    else if (tick_o) gap_q <= '0;
    else             gap_q <= gap_q + 1'b1;
  end

  // R4: ticks are exactly DIV clocks apart, first one DIV edges after reset
  a_r4_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (gap_q == (DW+1)'(DIV - 1)));
  a_r4_no_early_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gap_q < (DW+1)'(DIV - 1)) |-> !tick_o);
endmodule

// File: rtl/pacc_core.sv
module pacc_core
  import pacc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic       prev_i,
  input  logic       tick_i,
  input  logic       mode_gated_i,
  input  logic       pol_i,
  input  logic       en_i,
  input  logic       cnt_wr_i,
  input  cnt_t       cnt_wdata_i,
  input  logic       flag_clr_wr_i,
  input  logic [1:0] flag_clr_i,
  output cnt_t       count_o,
  output logic       ovf_o,
  output logic       inflag_o
);
  cnt_t       cnt_q;
  logic       ovf_q, inf_q;
  logic       ev_hit, trail_hit, active, do_inc, set_ovf, set_in;
  logic [CW:0] nxt;

  assign ev_hit    = sel_edge(lvl_i, prev_i, pol_i);
  assign trail_hit = sel_edge(lvl_i, prev_i, ~pol_i);
  assign active    = lvl_i ^ pol_i;
  assign do_inc    = en_i & (mode_gated_i ? (tick_i & active) : ev_hit);
  assign nxt       = bump(cnt_q);
  assign set_ovf   = do_inc & ~cnt_wr_i & nxt[CW];
  assign set_in    = en_i & (mode_gated_i ? trail_hit : ev_hit);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (cnt_wr_i) cnt_q <= cnt_wdata_i;
    else if (do_inc)   cnt_q <= nxt[CW-1:0];
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      inf_q <= 1'b0;
    end else begin
      ovf_q <= set_ovf | (ovf_q & ~(flag_clr_wr_i & flag_clr_i[0]));
      inf_q <= set_in  | (inf_q & ~(flag_clr_wr_i & flag_clr_i[1]));
    end
  end

  assign count_o  = cnt_q;
  assign ovf_o    = ovf_q;
  assign inflag_o = inf_q;

  // R8: a write always lands, advance or not
  a_r8_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> (count_o == $past(cnt_wdata_i)));
  // R6: wrap sets overflow
  a_r6_wrap_sets_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_inc && !cnt_wr_i && cnt_q == 8'hFF) |=> (ovf_o && count_o == 8'h00));
  // R5: disabled accumulator holds its count without a write
  a_r5_hold_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cnt_wr_i) |=> $stable(count_o));
  // R3: event mode holds without a selected transition
  a_r3_no_edge_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_gated_i && !ev_hit && !cnt_wr_i) |=> $stable(count_o));
  // R4: gated mode holds while pin is inactive
  a_r4_inactive_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_gated_i && !active && !cnt_wr_i) |=> $stable(count_o));
  // R9: clear without a set empties the flag
  a_r9_clear_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_wr_i && flag_clr_i[0] && !set_ovf) |=> !ovf_o);
  // R7: input flag rises only from a set event
  a_r7_inflag_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(inflag_o) |-> $past(set_in));
endmodule

// File: rtl/pacc_top.sv
module pacc_top
  import pacc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TICK_DIV    = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic       mode_gated_i,
  input  logic       pol_i,
  input  logic       en_i,
  input  logic       cnt_wr_i,
  input  logic [7:0] cnt_wdata_i,
  input  logic       flag_clr_wr_i,
  input  logic [1:0] flag_clr_i,
  input  logic       ie_ovf_i,
  input  logic       ie_in_i,
  output logic [7:0] count_o,
  output logic       ovf_flag_o,
  output logic       in_flag_o,
  output logic       irq_ovf_o,
  output logic       irq_in_o
);
  logic lvl_w, prev_w, tick_w;

  pacc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i),
    .lvl_o(lvl_w), .prev_o(prev_w)
  );

  pacc_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick_w)
  );

  pacc_core u_core (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lvl_i(lvl_w), .prev_i(prev_w), .tick_i(tick_w),
    .mode_gated_i(mode_gated_i), .pol_i(pol_i), .en_i(en_i),
    .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i),
    .flag_clr_wr_i(flag_clr_wr_i), .flag_clr_i(flag_clr_i),
    .count_o(count_o), .ovf_o(ovf_flag_o), .inflag_o(in_flag_o)
  );

  assign irq_ovf_o = ovf_flag_o & ie_ovf_i;
  assign irq_in_o  = in_flag_o & ie_in_i;

  // R10: a request never appears without its flag
  a_r10_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ovf_o || irq_in_o) |-> (ovf_flag_o || in_flag_o));
  // R1: first cycle after reset is clean
  a_r1_reset_clean: assert property (@(posedge clk_i)
    !rst_ni |=> (count_o == 8'h00 && !ovf_flag_o && !in_flag_o));
endmodule

// File: tb/tb_pacc_top.sv
module tb_pacc_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0, mode_g = 1'b0, pol = 1'b0, en = 1'b0;
  logic       cwr = 1'b0, fclr_wr = 1'b0, ie_o = 1'b0, ie_i = 1'b0;
  logic [7:0] cwd = 8'h00;
  logic [1:0] fclr = 2'b00;
  logic [7:0] count;
  logic       ovf, inf, irq_o, irq_i;

  int n_run = 0, n_fail = 0;
  string phase = "R1";

  always #4 clk = ~clk; // 125 MHz

  pacc_top dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .mode_gated_i(mode_g),
    .pol_i(pol), .en_i(en), .cnt_wr_i(cwr), .cnt_wdata_i(cwd),
    .flag_clr_wr_i(fclr_wr), .flag_clr_i(fclr), .ie_ovf_i(ie_o), .ie_in_i(ie_i),
    .count_o(count), .ovf_flag_o(ovf), .in_flag_o(inf),
    .irq_ovf_o(irq_o), .irq_in_o(irq_i)
  );

  // Expected item: count, ovf, in flag, irq_ovf, irq_in
  typedef struct { int c; bit o; bit f; bit io; bit ii; string tag; } exp_t;
  exp_t q[$];

  // Reference model state, written from the requirements.
  bit m_a, m_b, m_old;   // synchronizer stages and previous level
  int m_c, m_div;
  bit m_o, m_f;

  function automatic void check(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endfunction

  // Driver-side model: at each edge compute what the outputs become and queue it.
  always @(posedge clk) begin
    exp_t e;
    bit tick, want, trailing, adv, lv;
    if (!rst_n) begin
      m_a = 0; m_b = 0; m_old = 0; m_c = 0; m_div = 0; m_o = 0; m_f = 0;
    end else begin
      lv = m_b;
      want     = pol ? (m_old && !lv) : (!m_old && lv);
      trailing = pol ? (!m_old && lv) : (m_old && !lv);
      m_div    = m_div + 1;
      tick     = (m_div % 256 == 0);
      adv = en && (mode_g ? (tick && (lv != pol)) : want);
      if (fclr_wr && fclr[0]) m_o = 0;
      if (fclr_wr && fclr[1]) m_f = 0;
      if (en && (mode_g ? trailing : want)) m_f = 1;
      if (cwr) m_c = cwd;
      else if (adv) begin
        if (m_c == 255) begin m_c = 0; m_o = 1; end
        else m_c = m_c + 1;
      end
      m_old = lv; m_b = m_a; m_a = pin;
    end
    e.c = m_c; e.o = m_o; e.f = m_f;
    e.io = m_o && ie_o; e.ii = m_f && ie_i; e.tag = phase;
    q.push_back(e);
  end

  // Monitor: compare at the falling edge, after outputs settle.
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      e.io = m_o && ie_o; e.ii = m_f && ie_i;
      check(e.tag, "count", count, e.c);
      check(e.tag, "ovf",   ovf,   e.o);
      check(e.tag, "inflag", inf,  e.f);
      check("R10", "irq_ovf", irq_o, e.io);
      check("R10", "irq_in",  irq_i, e.ii);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(int hi, int lo);
    pin = 1'b1; idle(hi); pin = 1'b0; idle(lo);
  endtask

  task automatic clear(logic [1:0] m);
    fclr = m; fclr_wr = 1'b1; idle(1); fclr_wr = 1'b0; fclr = 2'b00;
  endtask

  task automatic preload(logic [7:0] v);
    cwd = v; cwr = 1'b1; idle(1); cwr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    phase = "R1";
    idle(3);
    check("R1", "count in reset", count, 0);
    check("R1", "ovf in reset", ovf, 0);
    rst_n = 1'b1; en = 1'b1; ie_o = 1'b1; ie_i = 1'b1;
    idle(2);
    // Event mode, rising edges.
    phase = "R3";
    for (int i = 0; i < 5; i++) pulse(3, 4);
    // Synchronizer latency, single short pulse.
    phase = "R2";
    pulse(1, 1); idle(4);
    // Falling edges.
    phase = "R3"; pol = 1'b1;
    for (int i = 0; i < 4; i++) pulse(2, 5);
    clear(2'b10); pol = 1'b0;
    // Disabled.
    phase = "R5"; en = 1'b0;
    for (int i = 0; i < 3; i++) pulse(2, 2);
    en = 1'b1; idle(3);
    // Wrap and overflow.
    phase = "R6"; preload(8'hFD);
    for (int i = 0; i < 5; i++) pulse(2, 3);
    // Clears: set wins, mask 0 keeps.
    phase = "R9"; clear(2'b00); clear(2'b01); clear(2'b10);
    pin = 1'b1; idle(2); fclr = 2'b10; fclr_wr = 1'b1; idle(1);
    fclr_wr = 1'b0; fclr = 2'b00; idle(3); pin = 1'b0; idle(3);
    clear(2'b11);
    // Write collides with an advance.
    phase = "R8"; pin = 1'b1; idle(2); cwd = 8'h42; cwr = 1'b1; idle(1);
    cwr = 1'b0; idle(2); pin = 1'b0; idle(3);
    preload(8'hFF); pin = 1'b1; idle(2); cwd = 8'h10; cwr = 1'b1; idle(1);
    cwr = 1'b0; idle(3); pin = 1'b0; idle(3);
    // Interrupt enables.
    phase = "R10"; ie_o = 1'b0; idle(2); ie_i = 1'b0; idle(2);
    ie_o = 1'b1; ie_i = 1'b1; clear(2'b11);
    // Gated, active high, then trailing edge.
    phase = "R4"; mode_g = 1'b1; preload(8'h00);
    pin = 1'b1; idle(900); phase = "R7"; pin = 1'b0; idle(300);
    clear(2'b11);
    // Gated, active low, wrap through ticks.
    phase = "R4"; pol = 1'b1; preload(8'hFE);
    idle(1000); phase = "R7"; pin = 1'b1; idle(50);
    // Gated while disabled.
    phase = "R5"; en = 1'b0; pin = 1'b0; idle(600); pin = 1'b1; idle(10);
    // Reset again mid-run.
    phase = "R1"; rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
    check("R1", "count after reset", count, 0);
    idle(4);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule